// File: doc/BRIEF.md
# Serial Memory Write Guard

This block holds the status byte of a byte-addressed serial memory with an 8K x 8 array and decides, cycle by cycle, whether each write request from a command front end may proceed. The front end hands over already-decoded requests: set or clear the write-enable latch, write the status byte with a data byte, or write one array byte at a 13-bit address. The block also watches the active-low external write-protect pin.

An accepted write starts an internal write cycle whose length is a parameter. While it runs, the status byte reads as all ones and every request is turned away. When it ends, the write-enable latch drops and any new protection settings carried by a status write become effective. A two-bit protection level locks nothing, the top quarter, the top half or the whole array. A sticky enable bit, together with a low protect pin, freezes the status byte itself.

The allow or deny decision for each status or array write appears on registered outputs one cycle after the request.

Top module: `sermem_guard`

## Requirements
- R1: After a synchronous reset the write-enable latch and busy flag are 0, the protection level and the sticky protect-enable bit hold their power-up parameters, and no grant or deny output is high.
- R2: When idle, the status byte is bit0 = busy (0), bit1 = write-enable latch, bit2 = level low bit, bit3 = level high bit, bit7 = sticky protect-enable, and bits 4 to 6 are 0.
- R3: While an internal write cycle runs, the status byte reads 8'hFF.
- R4: An array write is denied if its address lies in the locked zone. Level 00 locks nothing, 01 locks 0x1800 to 0x1FFF, 10 locks 0x1000 to 0x1FFF, and 11 locks 0x0000 to 0x1FFF.
- R5: A status or array write made while the write-enable latch is 0 is denied. Each request raises exactly one of its grant or deny outputs, in the cycle after the request.
- R6: When the pin is low and the sticky protect-enable bit is 1, every status write is denied. Array writes outside the locked zone are still granted.
- R7: While an internal write cycle runs, write requests are denied and the latch set and clear requests are ignored.
- R8: A granted write keeps the busy flag set for exactly WRITE_CYCLES cycles. At the end the latch clears. A status write's level bits (data bits 3:2) and protect-enable bit (data bit 7) take effect only then.
- R9: If a status write and an array write arrive in the same cycle, the status write is judged and the array write is denied.
- R10: A latch clear and a latch set in the same idle cycle leave the latch at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wel_set_i | input | 1 | Set the write-enable latch |
| wel_clr_i | input | 1 | Clear the write-enable latch |
| sr_wr_i | input | 1 | Status write request |
| sr_data_i | input | 8 | Status write data byte |
| arr_wr_i | input | 1 | Array write request |
| arr_addr_i | input | ADDR_W | Array write address |
| wp_n_i | input | 1 | External write-protect pin, active low |
| status_o | output | 8 | Status byte for a status read |
| sr_grant_o | output | 1 | Previous-cycle status write accepted |
| sr_deny_o | output | 1 | Previous-cycle status write rejected |
| arr_grant_o | output | 1 | Previous-cycle array write accepted |
| arr_deny_o | output | 1 | Previous-cycle array write rejected |

## Verification
The two functions that can meet in one cycle are a status write and an array write. The bench raises both requests together while the latch is set. The reference model expects the status write to be judged alone and the array request to be denied. The end of an internal write cycle can also meet a latch set request. That case is provoked by random stimulus, and the model judges it by showing the latch at 0 once the busy flag falls.

// File: rtl/smg_pkg.sv
package smg_pkg;
  localparam int ST_BUSY = 0;
  localparam int ST_WEN  = 1;
  localparam int ST_LVL0 = 2;
  localparam int ST_LVL1 = 3;
  localparam int ST_PEN  = 7;

  typedef logic [1:0] lock_lvl_t;

  function automatic logic [7:0] pack_status(input logic busy, input logic wen,
                                             input lock_lvl_t lvl, input logic pen);
    logic [7:0] s;
    s = 8'h00;
    s[ST_BUSY] = busy;
    s[ST_WEN]  = wen;
    s[ST_LVL0] = lvl[0];
    s[ST_LVL1] = lvl[1];
    s[ST_PEN]  = pen;
    return busy ? 8'hFF : s;
  endfunction
endpackage

// File: rtl/smg_zone_decode.sv
module smg_zone_decode
  import smg_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  lock_lvl_t         lvl,
  input  logic [ADDR_W-1:0] addr,
  output logic              locked
);
  localparam logic [1:0] TOP_Q = 2'b11;

  logic top_quarter;
  logic top_half;

  assign top_quarter = (addr[ADDR_W-1 -: 2] == TOP_Q);
  assign top_half    = addr[ADDR_W-1];

  always_comb begin
    unique case (lvl)
      2'b00:   locked = 1'b0;
      2'b01:   locked = top_quarter;
      2'b10:   locked = top_half;
      default: locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/smg_write_timer.sv
module smg_write_timer #(
  parameter int WRITE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(WRITE_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  p_cnt_range_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= LOAD));
  p_start_loads_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && cnt == LOAD));
endmodule

// File: rtl/smg_enable_latch.sv
module smg_enable_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  input  logic hold,
  input  logic cycle_end,
  output logic wen
);
  always_ff @(posedge clk) begin
    if (rst)            wen <= 1'b0;
    else if (cycle_end) wen <= 1'b0;
    else if (!hold) begin
      if (clr_req)      wen <= 1'b0;
      else if (set_req) wen <= 1'b1;
    end
  end

  p_clr_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !hold) |=> !wen);
  p_hold_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    (hold && !cycle_end) |=> $stable(wen));
endmodule

// File: rtl/sermem_guard.sv
module sermem_guard
  import smg_pkg::*;
#(
  parameter int        ADDR_W       = 13,
  parameter int        WRITE_CYCLES = 8,
  parameter lock_lvl_t INIT_LVL     = 2'b00,
  parameter logic      INIT_PEN     = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wel_set_i,
  input  logic              wel_clr_i,
  input  logic              sr_wr_i,
  input  logic [7:0]        sr_data_i,
  input  logic              arr_wr_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  input  logic              wp_n_i,
  output logic [7:0]        status_o,
  output logic              sr_grant_o,
  output logic              sr_deny_o,
  output logic              arr_grant_o,
  output logic              arr_deny_o
);
  lock_lvl_t lvl_q, lvl_pend;
  logic      pen_q, pen_pend, pend_v;
  logic      busy, done, wen;
  logic      hw_lock, zone_hit, sr_ok, arr_ok, start;

  smg_zone_decode #(.ADDR_W(ADDR_W)) u_zone (
    .lvl(lvl_q), .addr(arr_addr_i), .locked(zone_hit)
  );

  smg_write_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done)
  );

  smg_enable_latch u_wel (
    .clk(clk), .rst(rst), .set_req(wel_set_i), .clr_req(wel_clr_i),
    .hold(busy), .cycle_end(done), .wen(wen)
  );

  assign hw_lock = !wp_n_i && pen_q;
  assign sr_ok   = sr_wr_i && !busy && wen && !hw_lock;
  assign arr_ok  = arr_wr_i && !sr_wr_i && !busy && wen && !zone_hit;
  assign start   = sr_ok || arr_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_grant_o  <= 1'b0;
      sr_deny_o   <= 1'b0;
      arr_grant_o <= 1'b0;
      arr_deny_o  <= 1'b0;
      lvl_q       <= INIT_LVL;
      pen_q       <= INIT_PEN;
      lvl_pend    <= INIT_LVL;
      pen_pend    <= INIT_PEN;
      pend_v      <= 1'b0;
    end else begin
      sr_grant_o  <= sr_ok;
      sr_deny_o   <= sr_wr_i && !sr_ok;
      arr_grant_o <= arr_ok;
      arr_deny_o  <= arr_wr_i && !arr_ok;
      if (sr_ok) begin
        lvl_pend <= {sr_data_i[ST_LVL1], sr_data_i[ST_LVL0]};
        pen_pend <= sr_data_i[ST_PEN];
        pend_v   <= 1'b1;
      end else if (arr_ok) begin
        pend_v <= 1'b0;
      end else if (done) begin
        pend_v <= 1'b0;
        if (pend_v) begin
          lvl_q <= lvl_pend;
          pen_q <= pen_pend;
        end
      end
    end
  end

  assign status_o = pack_status(busy, wen, lvl_q, pen_q);

  p_idle_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !status_o[ST_BUSY] |-> (status_o[6:4] == 3'b000));
  p_busy_ones_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (status_o == 8'hFF));
  p_full_lock_r4: assert property (@(posedge clk) disable iff (rst)
    (arr_wr_i && lvl_q == 2'b11) |=> !arr_grant_o);
  p_nowen_deny_r5: assert property (@(posedge clk) disable iff (rst)
    (sr_wr_i && !wen) |=> sr_deny_o);
  p_one_outcome_r5: assert property (@(posedge clk) disable iff (rst)
    !(sr_grant_o && sr_deny_o) && !(arr_grant_o && arr_deny_o));
  p_hw_lock_r6: assert property (@(posedge clk) disable iff (rst)
    (sr_wr_i && !wp_n_i && pen_q) |=> sr_deny_o);
  p_busy_reject_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && (sr_wr_i || arr_wr_i)) |=> (!sr_grant_o && !arr_grant_o));
  p_grant_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (sr_grant_o || arr_grant_o) |-> busy);
  p_end_clears_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wen);
  p_lvl_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(lvl_q) && $stable(pen_q));
  p_pair_r9: assert property (@(posedge clk) disable iff (rst)
    (sr_wr_i && arr_wr_i) |=> arr_deny_o);
endmodule

// File: tb/sermem_guard_test.sv
`timescale 1ns/1ps
module sermem_guard_test;
  localparam int         AW   = 13;
  localparam int         WC   = 8;
  localparam logic [1:0] ILVL = 2'b00;
  localparam logic       IPEN = 1'b0;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst, wel_set, wel_clr, sr_wr, arr_wr, wp_n;
  logic [7:0]    sr_data;
  logic [AW-1:0] arr_addr;
  logic [7:0]    status;
  logic          sg, sd, ag, ad;

  sermem_guard #(.ADDR_W(AW), .WRITE_CYCLES(WC), .INIT_LVL(ILVL), .INIT_PEN(IPEN)) uut (
    .clk(clk), .rst(rst), .wel_set_i(wel_set), .wel_clr_i(wel_clr),
    .sr_wr_i(sr_wr), .sr_data_i(sr_data), .arr_wr_i(arr_wr), .arr_addr_i(arr_addr),
    .wp_n_i(wp_n), .status_o(status), .sr_grant_o(sg), .sr_deny_o(sd),
    .arr_grant_o(ag), .arr_deny_o(ad)
  );

  int    vectors = 0;
  int    errors  = 0;
  int    cyc     = 0;
  bit    armed   = 0;
  bit    over    = 0;
  string phase   = "R1";

  bit         m_wen, m_busy, m_pen, m_pv, m_ppen;
  int         m_left;
  logic [1:0] m_lvl, m_plvl;
  logic [3:0] m_dec;

  function automatic bit in_zone(logic [1:0] l, int a);
    case (l)
      2'b00:   return 1'b0;
      2'b01:   return a >= 'h1800;
      2'b10:   return a >= 'h1000;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] want_status();
    if (m_busy) return 8'hFF;
    return {m_pen, 3'b000, m_lvl, m_wen, 1'b0};
  endfunction

  always @(posedge clk) begin : model
    bit hw, sok, aok;
    cyc = cyc + 1;
    armed = 1'b1;
    if (rst) begin
      m_wen = 0; m_busy = 0; m_left = 0; m_lvl = ILVL; m_pen = IPEN; m_pv = 0;
      m_dec = 4'b0000;
    end else begin
      hw  = !wp_n && m_pen;
      sok = sr_wr && !m_busy && m_wen && !hw;
      aok = arr_wr && !sr_wr && !m_busy && m_wen && !in_zone(m_lvl, int'(arr_addr));
      m_dec = {sok, sr_wr && !sok, aok, arr_wr && !aok};
      if (m_busy) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_busy = 0;
          m_wen  = 0;
          if (m_pv) begin m_lvl = m_plvl; m_pen = m_ppen; m_pv = 0; end
        end
      end else begin
        if (wel_clr)      m_wen = 0;
        else if (wel_set) m_wen = 1;
      end
      if (sok || aok) begin
        m_busy = 1; m_left = WC; m_pv = sok;
        if (sok) begin m_plvl = {sr_data[3], sr_data[2]}; m_ppen = sr_data[7]; end
      end
    end
    if (cyc > 20000 && !over) begin
      errors = errors + 1;
      $display("FAIL watchdog in %s: got %0d cycles, expected under 20000", phase, cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (armed && !over) begin
      vectors = vectors + 1;
      if (status !== want_status()) begin
        errors = errors + 1;
        $display("FAIL %s status: got %h expected %h", phase, status, want_status());
      end
      vectors = vectors + 1;
      if ({sg, sd, ag, ad} !== m_dec) begin
        errors = errors + 1;
        $display("FAIL %s grant/deny {sg,sd,ag,ad}: got %b expected %b", phase, {sg, sd, ag, ad}, m_dec);
      end
    end
  end

  task automatic drive(bit s, bit c, bit sw, logic [7:0] d, bit aw, int a);
    @(negedge clk);
    wel_set = s; wel_clr = c; sr_wr = sw; sr_data = d; arr_wr = aw; arr_addr = AW'(a);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 8'h00, 0, 0);
  endtask

  task automatic write_sr(logic [7:0] d);
    drive(1, 0, 0, 8'h00, 0, 0);
    drive(0, 0, 1, d, 0, 0);
    idle(WC + 2);
  endtask

  task automatic write_arr(int a);
    drive(1, 0, 0, 8'h00, 0, 0);
    drive(0, 0, 0, 8'h00, 1, a);
    idle(WC + 2);
  endtask

  initial begin
    rst = 1; wel_set = 0; wel_clr = 0; sr_wr = 0; sr_data = 0; arr_wr = 0; arr_addr = 0; wp_n = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    phase = "R1"; idle(2);
    phase = "R5"; drive(0, 0, 1, 8'h0C, 0, 0); drive(0, 0, 0, 8'h00, 1, 0); idle(2);
    phase = "R10"; drive(1, 1, 0, 8'h00, 0, 0); idle(1); drive(1, 0, 0, 8'h00, 0, 0);
    drive(0, 1, 0, 8'h00, 0, 0); idle(1);
    phase = "R3 R8"; write_arr('h0000);
    phase = "R4"; write_sr(8'h04); write_arr('h17FF); write_arr('h1800);
    write_sr(8'h08); write_arr('h0FFF); write_arr('h1000);
    write_sr(8'h0C); write_arr('h0000); write_sr(8'h00); write_arr('h1FFF);
    phase = "R6"; write_sr(8'h80);
    wp_n = 0; write_sr(8'h0C); write_arr('h1FFF); write_arr('h0123);
    wp_n = 1; write_sr(8'h00);
    phase = "R7"; drive(1, 0, 0, 8'h00, 0, 0); drive(0, 0, 0, 8'h00, 1, 5);
    drive(0, 0, 1, 8'h04, 0, 0); drive(0, 0, 0, 8'h00, 1, 6); drive(1, 0, 0, 8'h00, 0, 0);
    drive(0, 1, 0, 8'h00, 0, 0); idle(WC);
    phase = "R9"; drive(1, 0, 0, 8'h00, 0, 0); drive(0, 0, 1, 8'h04, 1, 0); idle(WC + 2);
    write_sr(8'h00);
    phase = "R2 R5 R8";
    for (int i = 0; i < 600; i++) begin
      wp_n = ($urandom_range(0, 3) != 0);
      drive($urandom_range(0, 2) == 0, $urandom_range(0, 9) == 0, $urandom_range(0, 4) == 0,
            8'($urandom), $urandom_range(0, 3) == 0, int'($urandom_range(0, 8191)));
    end
    idle(WC + 2);
    over = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule